// File: doc/BRIEF.md
# Auto-Ranging Frequency Measurement Sequencer

This block gets one overflow-free frequency reading from a gated event counter that sits on a simple register bus. A one-cycle start pulse with a source index begins a measurement. The sequencer then acts as bus master and programs the counter with a long gate. It waits for the counter to finish, reads the count back, and checks it. If the count saturated, it shortens the gate by a fixed step and tries again. When an attempt fits, the count is converted to hertz and a precision bound is computed with one shared serial divider. The results then appear together with a one-cycle done pulse.

The counter has two registers. The control word at address 0 holds these fields: gate length minus one in bits 15:0, enable in bit 16, run in bit 19, source index in bits 26:20, and busy (read only) in bit 31. The count is read at address 8. The bus is a valid/ready handshake. A transfer completes in a cycle where both are high.

States: ST_IDLE (waiting for start), ST_CLEAR (zero the control word), ST_SETUP (write gate and source), ST_LAUNCH (add run and enable), ST_POLL (read control), ST_GAP (pause between reads), ST_HALT (drop enable), ST_FETCH (read count), ST_DIV_F (rate division), ST_DIV_P (precision division), ST_FINISH (done pulse). Transitions:
- ST_IDLE to ST_CLEAR on start.
- ST_CLEAR to ST_SETUP to ST_LAUNCH to ST_POLL, each on a completed transfer.
- ST_POLL to ST_GAP when the read shows busy.
- ST_GAP back to ST_POLL when the pause ends.
- ST_POLL to ST_HALT when the read shows busy clear.
- ST_POLL to ST_FINISH with error on the last allowed busy read.
- ST_HALT to ST_FETCH on a completed transfer.
- ST_FETCH to ST_CLEAR on overflow with a shorter gate still allowed.
- ST_FETCH to ST_FINISH with error on overflow at the shortest gate.
- ST_FETCH to ST_DIV_F on a usable count.
- ST_DIV_F to ST_DIV_P to ST_FINISH, each on quotient ready.
- ST_FINISH to ST_IDLE.

Top module: `mfs_autorange`

## Requirements
- R1: A start pulse in ST_IDLE latches the source index; the first attempt writes a gate field of 639 (a 640 us gate) and that source index into bits 26:20.
- R2: Each attempt performs, in order: write 0 to address 0; write gate-1 and source; write the same word with bits 16 and 19 set; read address 0 until bit 31 is clear; write the word with bit 16 cleared and bit 19 kept; read address 8.
- R3: A count of 0xFFFF or more is an overflow and starts a new attempt with the gate 32 us shorter; 0xFFFE is accepted.
- R4: If the attempt with the 32 us gate overflows, after 20 attempts in total, done rises with err high and both results zero.
- R5: The rate equals count x 1,000,000 / gate_us, rounded to nearest with halves rounded up.
- R6: The precision equals 2,000,000 / gate_us, rounded down, using the gate of the successful attempt.
- R7: Busy reads are separated by POLL_GAP idle cycles. If POLL_LIMIT reads all show busy, the sequence ends with err and no retry.
- R8: A bus request holds valid, write, address and data steady until ready is seen.
- R9: done is a one-cycle pulse, issued only after both quotients are ready; rate, precision and err hold their values until the next done.
- R10: A start pulse while a sequence is running is ignored: it produces no extra done and does not change the source used.
- R11: After reset, done, err, the rate, the precision and bus valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle measurement request |
| src_sel | input | SRC_W | Source index to measure |
| freq_hz | output | FREQ_W | Measured rate in Hz |
| prec_hz | output | PREC_W | Precision bound in Hz |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last sequence failed (overflow or timeout) |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_ready | input | 1 | Transfer accepted by the counter |
| bus_rdata | input | DATA_W | Read data, valid with bus_ready |

## Verification
Each result arrives a data-dependent number of cycles after start. The count depends on attempts, busy reads and slave wait states, plus two divisions of FREQ_W cycles each. done appears in the cycle after the precision quotient is ready. The scoreboard therefore does not predict a cycle number. It queues the expected item at start and compares rate, precision, err, attempt count and source at the falling edge of the cycle where done is high. Bus order and busy-read counts come from a transfer log that is taken on completed handshakes. Holding and pulse-width checks are made at every falling edge, between the edges where the design changes.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

    // Control word field positions decoded by the counter
    localparam int DUR_LSB  = 0;
    localparam int DUR_W    = 16;
    localparam int EN_BIT   = 16;
    localparam int RUN_BIT  = 19;
    localparam int SRC_LSB  = 20;
    localparam int BUSY_BIT = 31;

    localparam int MEGA     = 1_000_000;
    localparam int PREC_NUM = 2_000_000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_SETUP,
        ST_LAUNCH,
        ST_POLL,
        ST_GAP,
        ST_HALT,
        ST_FETCH,
        ST_DIV_F,
        ST_DIV_P,
        ST_FINISH
    } mfs_state_e;

endpackage

// File: rtl/mfs_divider.sv
module mfs_divider #(
    parameter int NUM_W = 36,
    parameter int DEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             done
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             done_q;
    logic [DEN_W:0]   shifted;
    logic [DEN_W:0]   diff;
    logic             fits;

    always_comb begin
        shifted = {rem_q, quo_q[NUM_W-1]};
        fits    = shifted >= {1'b0, den};
        diff    = shifted - {1'b0, den};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                quo_q <= num;
                rem_q <= '0;
                cnt_q <= CNT_W'(NUM_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
                quo_q <= {quo_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign quo  = quo_q;
    assign done = done_q;
endmodule

// File: rtl/mfs_poll_timer.sv
module mfs_poll_timer #(
    parameter int POLL_GAP   = 1000,
    parameter int POLL_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic poll_busy,
    input  logic gap_run,
    output logic gap_done,
    output logic last_poll
);
    localparam int GAP_W = $clog2(POLL_GAP + 1);
    localparam int LIM_W = $clog2(POLL_LIMIT + 1);

    logic [GAP_W-1:0] gap_q;
    logic [LIM_W-1:0] poll_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !gap_run) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            poll_q <= '0;
        end else if (poll_busy) begin
            poll_q <= poll_q + 1'b1;
        end
    end

    assign gap_done  = gap_run && (gap_q == GAP_W'(POLL_GAP - 1));
    assign last_poll = poll_q == LIM_W'(POLL_LIMIT - 1);
endmodule

// File: rtl/mfs_autorange.sv
module mfs_autorange
    import mfs_pkg::*;
#(
    parameter int GATE_MAX_US  = 640,
    parameter int GATE_STEP_US = 32,
    parameter int GATE_MIN_US  = 32,
    parameter int CNT_W        = 16,
    parameter int SRC_W        = 7,
    parameter int FREQ_W       = 36,
    parameter int PREC_W       = 16,
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 32,
    parameter int POLL_GAP     = 1000,
    parameter int POLL_LIMIT   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SRC_W-1:0]  src_sel,
    output logic [FREQ_W-1:0] freq_hz,
    output logic [PREC_W-1:0] prec_hz,
    output logic              done,
    output logic              err,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int GATE_W = $clog2(GATE_MAX_US + 1);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] CNT_ADDR  = ADDR_W'(8);
    localparam logic [DATA_W-1:0] CNT_SAT   = DATA_W'((64'd1 << CNT_W) - 1);
    localparam logic [GATE_W-1:0] GATE_LAST = GATE_W'(GATE_MIN_US + GATE_STEP_US);

    mfs_state_e state_q, state_d;

    logic [GATE_W-1:0] gate_q;
    logic [SRC_W-1:0]  src_q;
    logic [FREQ_W-1:0] freq_tmp_q, freq_q;
    logic [PREC_W-1:0] prec_q;
    logic              err_q;
    logic              fail_d;

    logic              xfer;
    logic              rd_busy;
    logic              rd_ovf;
    logic              gate_final;
    logic [DATA_W-1:0] cfg_word;

    logic              div_start, div_done;
    logic [FREQ_W-1:0] div_num, div_quo, freq_num;

    logic              gap_done, last_poll;

    // Shared status decodes
    always_comb begin
        xfer       = bus_valid && bus_ready;
        rd_busy    = bus_rdata[BUSY_BIT];
        rd_ovf     = bus_rdata >= CNT_SAT;
        gate_final = gate_q < GATE_LAST;
        cfg_word   = '0;
        cfg_word[DUR_LSB +: DUR_W]   = DUR_W'(gate_q - 1'b1);
        cfg_word[SRC_LSB +: SRC_W]   = src_q;
        freq_num   = FREQ_W'(bus_rdata[CNT_W-1:0]) * FREQ_W'(MEGA)
                   + FREQ_W'(gate_q >> 1);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        fail_d  = 1'b0;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CLEAR;
            ST_CLEAR:  if (xfer) state_d = ST_SETUP;
            ST_SETUP:  if (xfer) state_d = ST_LAUNCH;
            ST_LAUNCH: if (xfer) state_d = ST_POLL;
            ST_POLL: begin
                if (xfer) begin
                    if (!rd_busy) begin
                        state_d = ST_HALT;
                    end else if (last_poll) begin
                        state_d = ST_FINISH;
                        fail_d  = 1'b1;
                    end else begin
                        state_d = ST_GAP;
                    end
                end
            end
            ST_GAP:    if (gap_done) state_d = ST_POLL;
            ST_HALT:   if (xfer) state_d = ST_FETCH;
            ST_FETCH: begin
                if (xfer) begin
                    if (!rd_ovf) begin
                        state_d = ST_DIV_F;
                    end else if (gate_final) begin
                        state_d = ST_FINISH;
                        fail_d  = 1'b1;
                    end else begin
                        state_d = ST_CLEAR;
                    end
                end
            end
            ST_DIV_F:  if (div_done) state_d = ST_DIV_P;
            ST_DIV_P:  if (div_done) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Attempt and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q     <= GATE_W'(GATE_MAX_US);
            src_q      <= '0;
            freq_tmp_q <= '0;
            freq_q     <= '0;
            prec_q     <= '0;
            err_q      <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                src_q  <= src_sel;
                gate_q <= GATE_W'(GATE_MAX_US);
            end
            if (state_q == ST_FETCH && xfer && rd_ovf && !gate_final) begin
                gate_q <= gate_q - GATE_W'(GATE_STEP_US);
            end
            if (state_q == ST_DIV_F && div_done) begin
                freq_tmp_q <= div_quo;
            end
            if (state_q == ST_DIV_P && div_done) begin
                freq_q <= freq_tmp_q;
                prec_q <= div_quo[PREC_W-1:0];
                err_q  <= 1'b0;
            end
            if (fail_d) begin
                freq_q <= '0;
                prec_q <= '0;
                err_q  <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = CTRL_ADDR;
        bus_wdata = '0;
        unique case (state_q)
            ST_CLEAR: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
            end
            ST_SETUP: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_wdata = cfg_word;
            end
            ST_LAUNCH: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_wdata = cfg_word;
                bus_wdata[RUN_BIT] = 1'b1;
                bus_wdata[EN_BIT]  = 1'b1;
            end
            ST_POLL: bus_valid = 1'b1;
            ST_HALT: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_wdata = cfg_word;
                bus_wdata[RUN_BIT] = 1'b1;
            end
            ST_FETCH: begin
                bus_valid = 1'b1;
                bus_addr  = CNT_ADDR;
            end
            default: ;
        endcase
        done    = state_q == ST_FINISH;
        err     = err_q;
        freq_hz = freq_q;
        prec_hz = prec_q;
    end

    // Divider operand selection
    always_comb begin
        div_start = (state_q == ST_FETCH && xfer && !rd_ovf)
                 || (state_q == ST_DIV_F && div_done);
        div_num   = (state_q == ST_FETCH) ? freq_num : FREQ_W'(PREC_NUM);
    end

    mfs_divider #(
        .NUM_W (FREQ_W),
        .DEN_W (GATE_W)
    ) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (gate_q),
        .quo   (div_quo),
        .done  (div_done)
    );

    mfs_poll_timer #(
        .POLL_GAP   (POLL_GAP),
        .POLL_LIMIT (POLL_LIMIT)
    ) i_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state_q == ST_LAUNCH),
        .poll_busy (state_q == ST_POLL && xfer && rd_busy),
        .gap_run   (state_q == ST_GAP),
        .gap_done  (gap_done),
        .last_poll (last_poll)
    );
endmodule

// File: rtl/mfs_autorange_chk.sv
module mfs_autorange_chk #(
    parameter int GATE_MAX_US  = 640,
    parameter int GATE_STEP_US = 32,
    parameter int GATE_MIN_US  = 32,
    parameter int FREQ_W       = 36,
    parameter int PREC_W       = 16,
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              err,
    input logic [FREQ_W-1:0] freq_hz,
    input logic [PREC_W-1:0] prec_hz,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata
);
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_write)
            && $stable(bus_addr) && $stable(bus_wdata));

    a_r4_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done && err |-> freq_hz == '0 && prec_hz == '0);

    a_r3_gate_grid: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write && bus_wdata[16] |->
            (int'(bus_wdata[15:0]) + 1 >= GATE_MIN_US)
            && (int'(bus_wdata[15:0]) + 1 <= GATE_MAX_US)
            && ((int'(bus_wdata[15:0]) + 1) % GATE_STEP_US
                == GATE_MAX_US % GATE_STEP_US));

    a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !bus_valid);

    a_r6_prec_floor: assert property (@(posedge clk) disable iff (!rst_n)
        done && !err |-> int'(prec_hz) >= 2_000_000 / GATE_MAX_US);
endmodule

bind mfs_autorange mfs_autorange_chk #(
    .GATE_MAX_US  (GATE_MAX_US),
    .GATE_STEP_US (GATE_STEP_US),
    .GATE_MIN_US  (GATE_MIN_US),
    .FREQ_W       (FREQ_W),
    .PREC_W       (PREC_W),
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .err       (err),
    .freq_hz   (freq_hz),
    .prec_hz   (prec_hz),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/test_mfs_autorange.sv
module test_mfs_autorange;
    localparam int GAP      = 4;
    localparam int LIM      = 8;
    localparam int BUSY_CYC = 5;
    localparam int M_RATE   = 0;
    localparam int M_FIXED  = 1;
    localparam int M_HANG   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  src_sel = '0;
    logic [35:0] freq_hz;
    logic [15:0] prec_hz;
    logic        done, err;
    logic        bus_valid, bus_write, bus_ready;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    always #5 clk = ~clk;

    mfs_autorange #(.POLL_GAP(GAP), .POLL_LIMIT(LIM)) i_mfs_autorange (
        .clk(clk), .rst_n(rst_n), .start(start), .src_sel(src_sel),
        .freq_hz(freq_hz), .prec_hz(prec_hz), .done(done), .err(err),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // ---------------- counter model ----------------
    int     md = M_RATE;
    longint par = 50;
    logic        rdy_q;
    logic [31:0] ctrl_q, res_q;
    int          busy_cnt;
    int          attempts = 0;
    int          last_src = -1;
    bit          log_we[$];
    logic [3:0]  log_a[$];
    logic [31:0] log_w[$];

    function automatic longint model_count(int g);
        longint c;
        c = (md == M_RATE) ? par * g : par;
        if (c > 65535) c = 65535;
        return c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            rdy_q    <= 1'b0;
            ctrl_q   <= '0;
            res_q    <= '0;
            busy_cnt <= 0;
        end else begin
            rdy_q <= bus_valid && !rdy_q;
            if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
            if (bus_valid && rdy_q) begin
                log_we.push_back(bus_write);
                log_a.push_back(bus_addr);
                log_w.push_back(bus_wdata);
                if (bus_write && bus_addr == 4'd0) begin
                    ctrl_q <= bus_wdata;
                    if (bus_wdata[16] && bus_wdata[19]) begin
                        busy_cnt <= BUSY_CYC;
                        attempts <= attempts + 1;
                        last_src <= int'(bus_wdata[26:20]);
                        res_q    <= 32'(model_count(int'(bus_wdata[15:0]) + 1));
                    end
                end
            end
        end
    end

    assign bus_ready = rdy_q;
    assign bus_rdata = (bus_addr == 4'd8) ? res_q
                     : {(md == M_HANG) || (busy_cnt != 0), ctrl_q[30:0]};

    // ---------------- scoreboard ----------------
    typedef struct {
        int     src;
        longint freq;
        longint prec;
        bit     err;
        int     att;
        int     base;
    } exp_t;

    exp_t sb[$];

    function automatic exp_t predict(int src);
        exp_t e;
        int g = 640;
        longint c;
        e.src = src; e.att = 0; e.err = 0; e.freq = 0; e.prec = 0; e.base = 0;
        if (md == M_HANG) begin
            e.att = 1; e.err = 1;
            return e;
        end
        while (1) begin
            e.att++;
            c = model_count(g);
            if (c < 65535) begin
                e.freq = (c * 1000000 + g / 2) / g;
                e.prec = 2000000 / g;
                return e;
            end
            if (g - 32 < 32) begin
                e.err = 1;
                return e;
            end
            g -= 32;
        end
        return e;
    endfunction

    task automatic push_case(int src, int mode, longint p);
        exp_t e;
        md  = mode;
        par = p;
        e = predict(src);
        e.base = attempts;
        sb.push_back(e);
    endtask

    task automatic pulse_start(int src);
        @(negedge clk);
        start   = 1'b1;
        src_sel = 7'(src);
        @(negedge clk);
        start   = 1'b0;
    endtask

    task automatic wait_empty();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_case(int src, int mode, longint p);
        push_case(src, mode, p);
        pulse_start(src);
        wait_empty();
    endtask

    // monitor
    bit          prev_done = 1'b0;
    bit          pend_q = 1'b0;
    logic [3:0]  pa;
    logic [31:0] pw;
    bit          pwe;
    int          r8_viol = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pend_q && (!bus_valid || bus_addr != pa || bus_wdata != pw
                           || bus_write != pwe))
                r8_viol++;
            pend_q = bus_valid && !bus_ready;
            pa = bus_addr; pw = bus_wdata; pwe = bus_write;
            if (done) begin
                if (prev_done) check(1'b0, "R9", "done width", 2, 1);
                if (sb.size() == 0) begin
                    check(1'b0, "R10", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(freq_hz == 36'(e.freq), "R5", "freq_hz", freq_hz, e.freq);
                    check(prec_hz == 16'(e.prec), "R6", "prec_hz", prec_hz, e.prec);
                    check(err == e.err, e.err ? "R4" : "R3", "err", err, e.err);
                    check(attempts - e.base == e.att, "R3", "attempts",
                          attempts - e.base, e.att);
                    check(last_src == e.src, "R1", "source", last_src, e.src);
                end
            end
            prev_done = done;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WD", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        int b;
        int i;
        int reads;
        logic [35:0] held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(done == 0 && err == 0, "R11", "done/err after reset", {done, err}, 0);
        check(freq_hz == 0 && prec_hz == 0, "R11", "results after reset", freq_hz, 0);
        check(bus_valid == 0, "R11", "bus idle after reset", bus_valid, 0);

        // R2 / R1: single attempt at 640 us, bus order
        b = log_w.size();
        run_case(5, M_RATE, 50);
        i = b;
        check(log_we[i] && log_a[i] == 0 && log_w[i] == 0, "R2", "clear write", log_w[i], 0);
        i++;
        check(log_we[i] && log_w[i] == ((32'd5 << 20) | 32'd639), "R1", "setup word",
              log_w[i], (32'd5 << 20) | 32'd639);
        i++;
        check(log_we[i] && log_w[i] == ((32'd5 << 20) | 32'd639 | 32'h0009_0000), "R2",
              "launch word", log_w[i], (32'd5 << 20) | 32'd639 | 32'h0009_0000);
        i++;
        reads = 0;
        while (!log_we[i] && log_a[i] == 0) begin reads++; i++; end
        check(reads >= 1, "R2", "busy reads", reads, 1);
        check(log_we[i] && log_w[i] == ((32'd5 << 20) | 32'd639 | 32'h0008_0000), "R2",
              "enable drop word", log_w[i], (32'd5 << 20) | 32'd639 | 32'h0008_0000);
        i++;
        check(!log_we[i] && log_a[i] == 8, "R2", "count read addr", log_a[i], 8);
        check(i + 1 == log_w.size(), "R2", "transfer total", log_w.size(), i + 1);

        // R3: retries down to 320 us
        run_case(17, M_RATE, 200);
        // R5: halves round up
        run_case(3, M_FIXED, 1001);
        run_case(4, M_FIXED, 7);
        // R3: 0xFFFE accepted
        run_case(6, M_FIXED, 65534);
        // R6: shortest gate succeeds
        run_case(8, M_RATE, 2000);
        // R4: every attempt overflows
        run_case(11, M_FIXED, 65535);

        // R7: busy never clears
        b = log_w.size();
        run_case(12, M_HANG, 0);
        reads = 0;
        for (int k = b; k < log_w.size(); k++)
            if (!log_we[k] && log_a[k] == 0) reads++;
        check(reads == LIM, "R7", "busy reads before timeout", reads, LIM);

        // R9: results hold after done
        run_case(2, M_RATE, 40);
        held = freq_hz;
        repeat (10) @(negedge clk);
        check(freq_hz == held && !done, "R9", "held rate", freq_hz, held);

        // R10: start during a sequence is ignored
        push_case(9, M_RATE, 50);
        pulse_start(9);
        repeat (20) @(negedge clk);
        pulse_start(100);
        wait_empty();
        repeat (60) @(negedge clk);
        check(bus_valid == 0, "R10", "no second sequence", bus_valid, 0);

        check(r8_viol == 0, "R8", "request stability violations", r8_viol, 0);
        summary();
    end
endmodule